// File: doc/BRIEF.md
# Instruction Count Debug Trigger

This block is one debug trigger that watches the core's instruction retire stream and counts down a programmed number of instructions. When the last counted instruction retires, the trigger does not stop the core straight away. It only records that it is due. The breakpoint exception is requested later, just before the next instruction starts in a privilege mode the trigger is enabled for. Software can use it to step forward by exactly one instruction. This matters on cores whose address-match breakpoints have no way to resume over the breakpointed instruction.

Software programs and polls the trigger through a single CSR-style word. A write loads every field at once. A read returns the live count, the due flag and the mode enables. The core supplies two strobes, each paired with a privilege mode:

- a retire strobe, for the instruction that just completed;
- an issue strobe, for the instruction about to begin.

The block answers with a one-cycle exception request, driven combinationally in the same cycle as the issue strobe.

A build-time parameter selects a variant whose count is fixed at 1. In that variant, firing also clears all mode enables, so that software can later see that the trigger has gone off.

Top module: `icount_trigger`

## Requirements
- R1: After reset the word reads with the trigger type code 3 in bits XLEN-1:XLEN-4, zero in the debug-mode bit XLEN-5, and zero count, pending and enables. The fixed-count variant instead reads count 1. The fire output is low.
- R2: The word's field positions are:
  - bit 6: U enable
  - bit 7: S enable
  - bit 8: pending
  - bit 9: M enable
  - bits 23:10: 14-bit count
  - bit 25: VU enable
  - bit 26: VS enable

  A write loads all of these fields in the next cycle. All other bits always read as their fixed values.
- R3: With count greater than 1, a retire in an enabled mode lowers count by one in the next cycle.
- R4: Privilege codes are U=0, S=1, M=3, VU=4, VS=5. Codes 2, 6 and 7 are never enabled. A retire in a mode whose enable is clear leaves count and pending unchanged.
- R5: With count equal to 1, a retire in an enabled mode sets pending and, except in the fixed-count variant, sets count to 0 in the next cycle.
- R6: While pending is set, the fire output is high in the same cycle as an issue strobe whose mode is enabled. It stays low for an issue in a disabled mode and when no issue strobe is present.
- R7: Firing clears pending in the next cycle, so fire is never high in two consecutive cycles.
- R8: With count 0, or with every mode enable clear, retires never set pending and the trigger never fires.
- R9: A write has priority. A retire in the same cycle is ignored, and fire is held low in the write's cycle.
- R10: In the fixed-count variant, count always reads 1 and writes to it are dropped. Firing also clears the M, S, U, VS and VU enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_we | input | 1 | Write strobe for the trigger word |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Live trigger word |
| ret_valid | input | 1 | An instruction retired this cycle |
| ret_priv | input | 3 | Privilege mode of the retired instruction |
| issue_valid | input | 1 | An instruction is about to begin |
| issue_priv | input | 3 | Privilege mode of the instruction about to begin |
| dbg_fire | output | 1 | Take a debug exception before this instruction |

## Verification
The bench targets the two-phase handoff, where the count reaching zero and the exception being requested happen in different cycles:

- It retires the last counted instruction and then offers issues in a disabled mode before an enabled one. A design that fired at retire time, or on any issue, would pulse too early.
- It collides a write with a retire and with a pending issue. A design without write priority would show a decremented count or a stray pulse.
- It retires in reserved and disabled modes, and with count zero or all enables clear. These catch a decoder that counts the wrong modes.
- In the fixed-count variant, a second retire after firing must not re-arm the trigger, because the enables were cleared.

// File: rtl/icnt_pkg.sv
// Package: field positions, privilege codes and the enable bundle shared by
// the instruction-count trigger. Assumes XLEN of at least 32.
package icnt_pkg;

    localparam int POS_U      = 6;
    localparam int POS_S      = 7;
    localparam int POS_PEND   = 8;
    localparam int POS_M      = 9;
    localparam int POS_CNT_LO = 10;
    localparam int CNT_W      = 14;
    localparam int POS_VU     = 25;
    localparam int POS_VS     = 26;
    localparam int TYPE_W     = 4;
    localparam logic [TYPE_W-1:0] TYPE_ICOUNT = 4'd3;

    typedef enum logic [2:0] {
        PRIV_U  = 3'd0,
        PRIV_S  = 3'd1,
        PRIV_M  = 3'd3,
        PRIV_VU = 3'd4,
        PRIV_VS = 3'd5
    } priv_e;

    typedef struct packed {
        logic vs;
        logic vu;
        logic m;
        logic s;
        logic u;
    } mode_en_t;

endpackage

// File: rtl/icnt_mode_match.sv
// Mode match: tells whether a privilege code is one the trigger is enabled
// for. Purely combinational; reserved codes never match.
module icnt_mode_match
    import icnt_pkg::*;
(
    input  mode_en_t    en,
    input  logic [2:0]  priv,
    output logic        hit
);

    // Select the enable bit belonging to the given privilege code.
    always_comb begin
        unique case (priv)
            PRIV_U:  hit = en.u;
            PRIV_S:  hit = en.s;
            PRIV_M:  hit = en.m;
            PRIV_VU: hit = en.vu;
            PRIV_VS: hit = en.vs;
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/icnt_enable_reg.sv
// Enable register: holds the five mode enables. Loaded by a software write;
// cleared on fire when the owner asserts clear (fixed-count variant only).
// Assumes load and clear are never high together (the top gates fire by write).
module icnt_enable_reg
    import icnt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  mode_en_t load_en,
    input  logic     clear,
    output mode_en_t en
);

    // Write loads, fire-clear empties, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= '0;
        end else if (load) begin
            en <= load_en;
        end else if (clear) begin
            en <= '0;
        end
    end

endmodule

// File: rtl/icnt_count_unit.sv
// Count unit: the count field and the pending flag. A retire hit counts down;
// the hit on count 1 raises pending. Fire drops pending and wins over a
// simultaneous hit. FIXED_ONE selects a count hard-wired to 1.
// Assumes ret_hit and fire are already gated off during a write.
module icnt_count_unit #(
    parameter int CW        = 14,
    parameter bit FIXED_ONE = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_cnt,
    input  logic          load_pend,
    input  logic          ret_hit,
    input  logic          fire,
    output logic [CW-1:0] cnt,
    output logic          pend
);

    localparam logic [CW-1:0] ONE = CW'(1);

    logic last_hit;
    assign last_hit = ret_hit && (cnt == ONE);

    // Pending flag: load, clear on fire, set on the last counted retire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (load) begin
            pend <= load_pend;
        end else if (fire) begin
            pend <= 1'b0;
        end else if (last_hit) begin
            pend <= 1'b1;
        end
    end

    generate
        if (FIXED_ONE) begin : g_fixed
            // Count is a constant; written values are dropped.
            logic [CW-1:0] unused_load;
            assign unused_load = load_cnt;
            assign cnt = ONE;
        end else begin : g_counting
            logic [CW-1:0] cnt_q;
            // Count register: load, or step down on an enabled retire.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (load) begin
                    cnt_q <= load_cnt;
                end else if (ret_hit && (cnt_q != '0)) begin
                    cnt_q <= cnt_q - ONE;
                end
            end
            assign cnt = cnt_q;
        end
    endgenerate

endmodule

// File: rtl/icount_trigger.sv
// Instruction-count debug trigger top. Decodes software writes into the
// count unit and enable register, matches retire and issue modes, and
// requests a debug exception before an enabled instruction begins once the
// count is used up. dbg_fire is combinational from state and issue inputs.
// Assumes XLEN >= 32 and at most one retire and one issue per cycle.
module icount_trigger
    import icnt_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter bit FIXED_ONE = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            csr_we,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    input  logic            ret_valid,
    input  logic [2:0]      ret_priv,
    input  logic            issue_valid,
    input  logic [2:0]      issue_priv,
    output logic            dbg_fire
);

    localparam int TYPE_LO  = XLEN - TYPE_W;
    localparam int DMODE_AT = XLEN - TYPE_W - 1;

    mode_en_t         en;
    mode_en_t         wr_en;
    logic [CNT_W-1:0] cnt;
    logic             pend;
    logic             ret_match;
    logic             issue_match;
    logic             ret_hit;

    // Write-data field extraction.
    always_comb begin
        wr_en.u  = csr_wdata[POS_U];
        wr_en.s  = csr_wdata[POS_S];
        wr_en.m  = csr_wdata[POS_M];
        wr_en.vu = csr_wdata[POS_VU];
        wr_en.vs = csr_wdata[POS_VS];
    end

    icnt_mode_match u_ret_match (
        .en   (en),
        .priv (ret_priv),
        .hit  (ret_match)
    );

    icnt_mode_match u_issue_match (
        .en   (en),
        .priv (issue_priv),
        .hit  (issue_match)
    );

    assign ret_hit  = ret_valid && ret_match && !csr_we;
    assign dbg_fire = pend && issue_valid && issue_match && !csr_we;

    icnt_count_unit #(
        .CW        (CNT_W),
        .FIXED_ONE (FIXED_ONE)
    ) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (csr_we),
        .load_cnt  (csr_wdata[POS_CNT_LO +: CNT_W]),
        .load_pend (csr_wdata[POS_PEND]),
        .ret_hit   (ret_hit),
        .fire      (dbg_fire),
        .cnt       (cnt),
        .pend      (pend)
    );

    icnt_enable_reg u_enables (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (csr_we),
        .load_en (wr_en),
        .clear   (dbg_fire && FIXED_ONE),
        .en      (en)
    );

    // Read word assembly: type code, zero debug-mode bit, live fields.
    always_comb begin
        csr_rdata                        = '0;
        csr_rdata[XLEN-1:TYPE_LO]        = TYPE_ICOUNT;
        csr_rdata[DMODE_AT]              = 1'b0;
        csr_rdata[POS_U]                 = en.u;
        csr_rdata[POS_S]                 = en.s;
        csr_rdata[POS_PEND]              = pend;
        csr_rdata[POS_M]                 = en.m;
        csr_rdata[POS_CNT_LO +: CNT_W]   = cnt;
        csr_rdata[POS_VU]                = en.vu;
        csr_rdata[POS_VS]                = en.vs;
    end

endmodule

// File: rtl/icnt_checker.sv
// Checker: port-level properties of the instruction-count trigger, bound
// into every instance of the top module.
module icnt_checker
    import icnt_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            csr_we,
    input logic [XLEN-1:0] csr_wdata,
    input logic [XLEN-1:0] csr_rdata,
    input logic            ret_valid,
    input logic            issue_valid,
    input logic            dbg_fire
);

    logic [4:0] rd_en;
    logic [4:0] wr_en;
    assign rd_en = {csr_rdata[POS_VS], csr_rdata[POS_VU], csr_rdata[POS_M],
                    csr_rdata[POS_S], csr_rdata[POS_U]};
    assign wr_en = {csr_wdata[POS_VS], csr_wdata[POS_VU], csr_wdata[POS_M],
                    csr_wdata[POS_S], csr_wdata[POS_U]};

    AST_FIRE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_fire |-> csr_rdata[POS_PEND]); // R6
    AST_NO_FIRE_WITHOUT_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |-> !dbg_fire); // R6
    AST_FIRE_CLEARS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_fire |=> !csr_rdata[POS_PEND]); // R7
    AST_FIRE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_fire |=> !dbg_fire); // R7
    AST_WRITE_LOADS_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        csr_we |=> (rd_en == $past(wr_en)) && (csr_rdata[POS_PEND] == $past(csr_wdata[POS_PEND]))); // R2
    AST_WRITE_HOLDS_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        csr_we |-> !dbg_fire); // R9
    AST_COUNT_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!csr_we && !ret_valid) |=> $stable(csr_rdata[POS_CNT_LO +: CNT_W])); // R4

endmodule

bind icount_trigger icnt_checker #(.XLEN(XLEN)) u_icnt_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .csr_we      (csr_we),
    .csr_wdata   (csr_wdata),
    .csr_rdata   (csr_rdata),
    .ret_valid   (ret_valid),
    .issue_valid (issue_valid),
    .dbg_fire    (dbg_fire)
);

// File: tb/tb_icount_trigger.sv
// Scoreboard bench: the driver task applies one cycle of stimulus and queues
// the expected fire level and next read word; the monitor compares them.
module tb_icount_trigger;

    localparam int XLEN = 32;
    localparam logic [2:0] MU = 3'd0, MS = 3'd1, MR = 3'd2, MM = 3'd3,
                           MVU = 3'd4, MVS = 3'd5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk; // 125 MHz

    logic            we0 = 0, rv0 = 0, iv0 = 0, we1 = 0, rv1 = 0, iv1 = 0;
    logic [XLEN-1:0] wd0 = '0, wd1 = '0;
    logic [2:0]      rm0 = '0, im0 = '0, rm1 = '0, im1 = '0;
    logic [XLEN-1:0] rd0, rd1;
    logic            fire0, fire1;

    icount_trigger #(.XLEN(XLEN), .FIXED_ONE(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .csr_we(we0), .csr_wdata(wd0), .csr_rdata(rd0),
        .ret_valid(rv0), .ret_priv(rm0), .issue_valid(iv0), .issue_priv(im0),
        .dbg_fire(fire0));

    icount_trigger #(.XLEN(XLEN), .FIXED_ONE(1'b1)) dut_hw (
        .clk(clk), .rst_n(rst_n), .csr_we(we1), .csr_wdata(wd1), .csr_rdata(rd1),
        .ret_valid(rv1), .ret_priv(rm1), .issue_valid(iv1), .issue_priv(im1),
        .dbg_fire(fire1));

    typedef struct {
        bit              sel;
        bit              fire;
        logic [XLEN-1:0] rd;
        int              req;
    } exp_t;

    exp_t q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 0;

    function automatic logic [XLEN-1:0] td(int c, bit p, bit u, bit s, bit m, bit vu, bit vs);
        logic [XLEN-1:0] r;
        r = 32'h3000_0000;
        r[6] = u; r[7] = s; r[8] = p; r[9] = m;
        r[23:10] = c[13:0];
        r[25] = vu; r[26] = vs;
        return r;
    endfunction

    // Driver: one cycle of stimulus on the selected instance, expectation queued.
    task automatic step(input bit sel, input bit we, input logic [XLEN-1:0] wd,
                        input bit rv, input logic [2:0] rm, input bit iv,
                        input logic [2:0] im, input bit ef,
                        input logic [XLEN-1:0] er, input int req);
        exp_t it;
        @(negedge clk);
        we0 = 0; rv0 = 0; iv0 = 0; wd0 = '0; rm0 = '0; im0 = '0;
        we1 = 0; rv1 = 0; iv1 = 0; wd1 = '0; rm1 = '0; im1 = '0;
        if (!sel) begin
            we0 = we; wd0 = wd; rv0 = rv; rm0 = rm; iv0 = iv; im0 = im;
        end else begin
            we1 = we; wd1 = wd; rv1 = rv; rm1 = rm; iv1 = iv; im1 = im;
        end
        it.sel = sel; it.fire = ef; it.rd = er; it.req = req;
        q.push_back(it);
    endtask

    // Monitor: fire sampled before the edge, read word after it.
    initial begin
        bit              f0, f1, fa;
        logic [XLEN-1:0] ra;
        exp_t            it;
        forever begin
            @(negedge clk); #2;
            f0 = fire0; f1 = fire1;
            @(posedge clk); #2;
            if (q.size() > 0) begin
                it = q.pop_front();
                fa = it.sel ? f1 : f0;
                ra = it.sel ? rd1 : rd0;
                n_vec++;
                if (fa !== it.fire || ra !== it.rd) begin
                    n_bad++;
                    $display("FAIL R%0d: fire=%0b rdata=%h expected fire=%0b rdata=%h",
                             it.req, fa, ra, it.fire, it.rd);
                end
            end
        end
    end

    initial begin
        #(8 * 50000);
        if (!done) begin
            n_bad++;
            $display("FAIL R0: watchdog expired actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of both variants (R10 count reads 1)
        step(0, 0, 0, 0, MU, 0, MU, 0, td(0, 0, 0, 0, 0, 0, 0), 1);
        step(1, 0, 0, 0, MU, 0, MU, 0, td(1, 0, 0, 0, 0, 0, 0), 1);
        // R2: write count 3, U enabled
        step(0, 1, td(3, 0, 1, 0, 0, 0, 0), 0, MU, 0, MU, 0, td(3, 0, 1, 0, 0, 0, 0), 2);
        // R3: enabled retire counts down
        step(0, 0, 0, 1, MU, 0, MU, 0, td(2, 0, 1, 0, 0, 0, 0), 3);
        // R4: disabled and reserved modes leave count alone
        step(0, 0, 0, 1, MS, 0, MU, 0, td(2, 0, 1, 0, 0, 0, 0), 4);
        step(0, 0, 0, 1, MR, 0, MU, 0, td(2, 0, 1, 0, 0, 0, 0), 4);
        step(0, 0, 0, 1, MU, 0, MU, 0, td(1, 0, 1, 0, 0, 0, 0), 3);
        // R9: write wins over a same-cycle retire
        step(0, 1, td(1, 0, 1, 1, 0, 0, 0), 1, MU, 0, MU, 0, td(1, 0, 1, 1, 0, 0, 0), 9);
        step(0, 0, 0, 1, MM, 0, MU, 0, td(1, 0, 1, 1, 0, 0, 0), 4);
        // R5: last counted retire sets pending, count to 0
        step(0, 0, 0, 1, MS, 0, MU, 0, td(0, 1, 1, 1, 0, 0, 0), 5);
        // R6: issue in a disabled mode does not fire
        step(0, 0, 0, 0, MU, 1, MM, 0, td(0, 1, 1, 1, 0, 0, 0), 6);
        // R8: retire with count 0 changes nothing
        step(0, 0, 0, 1, MU, 0, MU, 0, td(0, 1, 1, 1, 0, 0, 0), 8);
        // R6 and R7: enabled issue fires, pending drops
        step(0, 0, 0, 0, MU, 1, MU, 1, td(0, 0, 1, 1, 0, 0, 0), 6);
        step(0, 0, 0, 0, MU, 1, MU, 0, td(0, 0, 1, 1, 0, 0, 0), 7);
        // R8: all enables clear, retires ignored
        step(0, 1, td(5, 0, 0, 0, 0, 0, 0), 0, MU, 0, MU, 0, td(5, 0, 0, 0, 0, 0, 0), 8);
        step(0, 0, 0, 1, MU, 0, MU, 0, td(5, 0, 0, 0, 0, 0, 0), 8);
        step(0, 0, 0, 1, MM, 0, MU, 0, td(5, 0, 0, 0, 0, 0, 0), 8);
        // R9: write during a would-be fire holds fire low
        step(0, 1, td(0, 1, 1, 0, 0, 0, 0), 0, MU, 0, MU, 0, td(0, 1, 1, 0, 0, 0, 0), 2);
        step(0, 1, td(0, 1, 0, 0, 0, 0, 1), 0, MU, 1, MU, 0, td(0, 1, 0, 0, 0, 0, 1), 9);
        // R6: VU disabled, VS enabled
        step(0, 0, 0, 0, MU, 1, MVU, 0, td(0, 1, 0, 0, 0, 0, 1), 6);
        step(0, 0, 0, 0, MU, 1, MVS, 1, td(0, 0, 0, 0, 0, 0, 1), 6);
        // R2: all-ones write, fixed bits keep their values
        step(0, 1, 32'hFFFF_FFFF, 0, MU, 0, MU, 0, td(16383, 1, 1, 1, 1, 1, 1), 2);
        // R8: count 0 with every mode enabled never arms
        step(0, 1, td(0, 0, 1, 1, 1, 1, 1), 0, MU, 0, MU, 0, td(0, 0, 1, 1, 1, 1, 1), 8);
        step(0, 0, 0, 1, MVU, 0, MU, 0, td(0, 0, 1, 1, 1, 1, 1), 8);
        step(0, 0, 0, 0, MU, 1, MM, 0, td(0, 0, 1, 1, 1, 1, 1), 8);
        // R10: fixed-count variant drops the written count
        step(1, 1, td(7, 0, 0, 0, 1, 0, 0), 0, MU, 0, MU, 0, td(1, 0, 0, 0, 1, 0, 0), 10);
        step(1, 0, 0, 1, MU, 0, MU, 0, td(1, 0, 0, 0, 1, 0, 0), 4);
        step(1, 0, 0, 1, MM, 0, MU, 0, td(1, 1, 0, 0, 1, 0, 0), 10);
        // R10: firing clears every enable
        step(1, 0, 0, 0, MU, 1, MM, 1, td(1, 0, 0, 0, 0, 0, 0), 10);
        step(1, 0, 0, 1, MM, 0, MU, 0, td(1, 0, 0, 0, 0, 0, 0), 10);
        step(1, 0, 0, 0, MU, 1, MM, 0, td(1, 0, 0, 0, 0, 0, 0), 7);
        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule